// File: doc/BRIEF.md
# Shared-Bus Sequenced ALU Datapath

This block is a small arithmetic datapath in which every value moves over one internal data bus. Two operand registers, a hidden temporary register and a result register hang off that bus. An ALU takes one operand straight from the temporary register and the other from the bus. Only one source may drive the bus in any cycle, so a small sequencer breaks each operation into separate transfers. First the left operand is parked in the temporary register. Next the right operand is driven while the ALU result is captured in the result register. Finally the result register is driven back into the left operand register.

A host preloads the two operand registers through an external bus source while the sequencer is idle. It then pulses `start` with a 3-bit operation code and waits for the one-cycle `done` pulse. A one-hot AND-OR multiplexer stands in for tristate drivers. When no source is enabled, the bus reads as zero.

Top module: `busalu_core`

## Requirements
- R1: After synchronous reset, both operand registers, the result register, `busy`, `done` and `bus_q` are all zero.
- R2: While idle and `start` is low, `pre_we` high loads `pre_data` at the next clock edge: into operand X when `pre_sel` is 0, into operand Y when `pre_sel` is 1. The other operand register is left unchanged.
- R3: While idle, a high `start` is captured at a clock edge together with `op`. `busy` is then high for four cycles. `done` is high only in the last of those four cycles, and `busy` and `done` fall together.
- R4: When `done` is high, operand X and the result register both hold f(X_old, Y_old), and operand Y holds Y_old.
- R5: Operation codes (W-bit, modulo 2^W): 000 X+Y, 001 X−Y, 010 X AND Y, 011 X OR Y, 100 X XOR Y, 101 copy Y. Codes 110 and 111 give zero.
- R6: A `start` raised while `busy` is high is ignored. The running operation keeps its code, exactly one `done` pulse appears, and the block returns to idle afterwards.
- R7: `pre_we` is ignored while `busy` is high. Neither operand register takes `pre_data`.
- R8: If `start` and `pre_we` are both high in the same idle cycle, the operation starts and the preload is discarded.
- R9: At most one source drives the bus in any cycle. `bus_q` shows `pre_data` during an idle preload, X in the first busy cycle and Y in the second. It reads zero when idle with no preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 3 | Operation code captured with `start` |
| pre_we | input | 1 | Preload request (idle only) |
| pre_sel | input | 1 | Preload target: 0 operand X, 1 operand Y |
| pre_data | input | W | Value driven onto the bus for a preload |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| a_q | output | W | Operand X register |
| b_q | output | W | Operand Y register |
| c_q | output | W | Result register |
| bus_q | output | W | Current value of the internal bus |

## Verification
Two things can land in the same idle cycle: a preload and a start, because both want to own the bus. The bench raises both together with preload data different from the current X. It then checks that the first busy cycle shows the old X on the bus and that the final result uses the old X.

A start or preload can also arrive while a sequence runs. These are raised in the first and second busy cycles. They are judged by the final register values and by there being no second `done` pulse. All operation codes are swept over a 16 by 16 operand grid, and expected results are computed arithmetically.

// File: rtl/busalu_pkg.sv
package busalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100,
        OP_PASS = 3'b101,
        OP_RSV6 = 3'b110,
        OP_RSV7 = 3'b111
    } alu_op_e;

    // Bus source indices; the one-hot enable vector uses these bit positions.
    localparam int NSRC    = 4;
    localparam int SRC_A   = 0;
    localparam int SRC_B   = 1;
    localparam int SRC_C   = 2;
    localparam int SRC_EXT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_A2T,
        ST_B2C,
        ST_C2A,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [NSRC-1:0] oe;
        logic            ld_a;
        logic            ld_b;
        logic            ld_t;
        logic            ld_c;
        alu_op_e         alu_op;
    } ctrl_t;

    function automatic logic [NSRC-1:0] src_bit(input int idx);
        logic [NSRC-1:0] r;
        r      = '0;
        r[idx] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/busalu_alu.sv
module busalu_alu
    import busalu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   lhs,
    input  logic [W-1:0]   rhs,
    output logic [W-1:0]   res
);

    always_comb begin
        case (op)
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_AND:  res = lhs & rhs;
            OP_OR:   res = lhs | rhs;
            OP_XOR:  res = lhs ^ rhs;
            OP_PASS: res = rhs;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/busalu_bus.sv
module busalu_bus
    import busalu_pkg::*;
#(
    parameter int W = 8,
    parameter int N = NSRC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        oe,
    input  logic [N-1:0][W-1:0] drv,
    output logic [W-1:0]        bus
);

    logic [N-1:0][W-1:0] masked;

    generate
        for (genvar i = 0; i < N; i++) begin : g_gate
            assign masked[i] = oe[i] ? drv[i] : '0;
        end
    endgenerate

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | masked[i];
        end
    end

    // R9
    bus_contention_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(oe));

endmodule

// File: rtl/busalu_seq.sv
module busalu_seq
    import busalu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] op_in,
    input  logic       pre_we,
    input  logic       pre_sel,
    output ctrl_t      cw,
    output logic       busy,
    output logic       done
);

    seq_state_e state_q;
    alu_op_e    op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_ADD;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_A2T;
                        op_q    <= alu_op_e'(op_in);
                    end
                end
                ST_A2T:  state_q <= ST_B2C;
                ST_B2C:  state_q <= ST_C2A;
                ST_C2A:  state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cw        = '0;
        cw.alu_op = op_q;
        case (state_q)
            ST_IDLE: begin
                if (pre_we && !start) begin
                    cw.oe = src_bit(SRC_EXT);
                    if (pre_sel) cw.ld_b = 1'b1;
                    else         cw.ld_a = 1'b1;
                end
            end
            ST_A2T: begin
                cw.oe   = src_bit(SRC_A);
                cw.ld_t = 1'b1;
            end
            ST_B2C: begin
                cw.oe   = src_bit(SRC_B);
                cw.ld_c = 1'b1;
            end
            ST_C2A: begin
                cw.oe   = src_bit(SRC_C);
                cw.ld_a = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> !busy);

endmodule

// File: rtl/busalu_core.sv
module busalu_core
    import busalu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic         pre_we,
    input  logic         pre_sel,
    input  logic [W-1:0] pre_data,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q,
    output logic [W-1:0] c_q,
    output logic [W-1:0] bus_q
);

    ctrl_t               cw;
    logic [W-1:0]        a_r, b_r, t_r, c_r;
    logic [W-1:0]        bus;
    logic [W-1:0]        alu_res;
    logic [NSRC-1:0][W-1:0] drv;

    busalu_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_in   (op),
        .pre_we  (pre_we),
        .pre_sel (pre_sel),
        .cw      (cw),
        .busy    (busy),
        .done    (done)
    );

    assign drv[SRC_A]   = a_r;
    assign drv[SRC_B]   = b_r;
    assign drv[SRC_C]   = c_r;
    assign drv[SRC_EXT] = pre_data;

    busalu_bus #(.W(W), .N(NSRC)) u_bus (
        .clk (clk),
        .rst (rst),
        .oe  (cw.oe),
        .drv (drv),
        .bus (bus)
    );

    busalu_alu #(.W(W)) u_alu (
        .op  (cw.alu_op),
        .lhs (t_r),
        .rhs (bus),
        .res (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_r <= '0;
            b_r <= '0;
            t_r <= '0;
            c_r <= '0;
        end else begin
            if (cw.ld_a) a_r <= bus;
            if (cw.ld_b) b_r <= bus;
            if (cw.ld_t) t_r <= bus;
            if (cw.ld_c) c_r <= alu_res;
        end
    end

    assign a_q   = a_r;
    assign b_q   = b_r;
    assign c_q   = c_r;
    assign bus_q = bus;

    // R4
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cw.ld_a |=> $stable(a_r));

    // R4
    done_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cw.ld_a));

    // R7
    b_quiet_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cw.ld_b);

endmodule

// File: tb/tb_busalu_core.sv
module tb_busalu_core;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [2:0]   op_i = 3'b000;
    logic         pre_we = 1'b0;
    logic         pre_sel = 1'b0;
    logic [W-1:0] pre_data = '0;
    logic         busy, done;
    logic [W-1:0] a_q, b_q, c_q, bus_q;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    busalu_core #(.W(W)) dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op       (op_i),
        .pre_we   (pre_we),
        .pre_sel  (pre_sel),
        .pre_data (pre_data),
        .busy     (busy),
        .done     (done),
        .a_q      (a_q),
        .b_q      (b_q),
        .c_q      (c_q),
        .bus_q    (bus_q)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(input int op, input int a, input int b);
        int r;
        case (op)
            0: r = a + b;
            1: r = a - b;
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = b;
            default: r = 0;
        endcase
        return r & ((1 << W) - 1);
    endfunction

    task automatic preload(input logic sel, input int data);
        @(negedge clk);
        pre_we = 1'b1; pre_sel = sel; pre_data = W'(data);
        #1 check("R9 preload bus", int'(bus_q), data);
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic run_op(input int op, input int a, input int b);
        int e;
        e = model(op, a, b);
        preload(1'b0, a);
        preload(1'b1, b);
        check("R2 X preload", int'(a_q), a);
        check("R2 Y preload", int'(b_q), b);
        start = 1'b1; op_i = 3'(op);
        @(negedge clk);
        start = 1'b0;
        check("R3 busy", int'(busy), 1);
        check("R3 done early", int'(done), 0);
        check("R9 X on bus", int'(bus_q), a);
        @(negedge clk);
        check("R9 Y on bus", int'(bus_q), b);
        check("R3 done early", int'(done), 0);
        @(negedge clk);
        check("R3 done early", int'(done), 0);
        @(negedge clk);
        check("R3 done", int'(done), 1);
        check("R5 X result", int'(a_q), e);
        check("R4 C result", int'(c_q), e);
        check("R4 Y kept", int'(b_q), b);
        @(negedge clk);
        check("R3 busy low", int'(busy), 0);
        check("R3 done low", int'(done), 0);
        check("R9 idle bus", int'(bus_q), 0);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog all R: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 X", int'(a_q), 0);
        check("R1 Y", int'(b_q), 0);
        check("R1 C", int'(c_q), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 bus", int'(bus_q), 0);

        // R5 sweep over all codes
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    run_op(o, (i * 17) & 255, (j * 23 + 5) & 255);

        // R2 preload of Y leaves X alone
        preload(1'b0, 77);
        preload(1'b1, 12);
        check("R2 X untouched", int'(a_q), 77);

        // R6 start while busy
        preload(1'b0, 10);
        preload(1'b1, 3);
        start = 1'b1; op_i = 3'b000;
        @(negedge clk);
        op_i = 3'b001;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6 done once", int'(done), 1);
        check("R6 op kept", int'(a_q), 13);
        @(negedge clk);
        check("R6 idle", int'(busy), 0);
        @(negedge clk);
        check("R6 no restart", int'(busy), 0);

        // R7 preload while busy
        preload(1'b0, 20);
        preload(1'b1, 7);
        start = 1'b1; op_i = 3'b100;
        @(negedge clk);
        start = 1'b0;
        pre_we = 1'b1; pre_sel = 1'b1; pre_data = 8'd99;
        @(negedge clk);
        pre_sel = 1'b0; pre_data = 8'd55;
        @(negedge clk);
        pre_we = 1'b0;
        @(negedge clk);
        check("R7 X", int'(a_q), 20 ^ 7);
        check("R7 Y", int'(b_q), 7);
        @(negedge clk);

        // R8 start and preload together
        preload(1'b0, 40);
        preload(1'b1, 2);
        @(negedge clk);
        start = 1'b1; op_i = 3'b000;
        pre_we = 1'b1; pre_sel = 1'b0; pre_data = 8'd200;
        @(negedge clk);
        start = 1'b0; pre_we = 1'b0;
        check("R8 old X on bus", int'(bus_q), 40);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R8 done", int'(done), 1);
        check("R8 result", int'(a_q), 42);
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule